// File: doc/BRIEF.md
# Daisy-Chain Serial Switch Controller

This block is a serial-bus slave that sets a small bank of analog-switch enable lines. A host writes a command over a four-wire synchronous serial link: a serial clock, an active-low select, a data input and a data output. Several of these slaves can share one select line and one clock. Each slave's data output feeds the next slave's data input, so the host needs four pins however many slaves there are.

Every slave holds an 8-bit shift register. The register shifts most significant bit first, and its top bit drives the data output. During a frame the stream moves through the chain one byte per slave. When the host releases the select line, every slave copies the low bits of its register onto its switch enables, all in the same moment. The clock idle level and the clock phase are fixed by parameters. The serial pins are brought into the system clock domain through synchronizers, so the serial clock must be several times slower than the system clock.

Top module: `spi_switch_slave`

## Requirements
- R1: While reset is high and after it is released, every switch enable is 0, the shift register holds all zeros and the output enable is 0. Bits shifted out in the first frame after reset are therefore 0.
- R2: While the select is high, toggling the serial clock or the data input changes neither the switch enables nor the shift register contents. The unchanged contents are seen when they are read back in the next frame.
- R3: With idle level parameter P, the leading edge is the transition away from level P. With phase parameter 0, data is sampled on the leading edge and shifted on the trailing edge. With phase parameter 1, data is shifted on the leading edge and sampled on the trailing edge. A leading edge and a trailing edge are never recognised in the same cycle.
- R4: Bits are shifted most significant first. The data output presents, one at a time, the bits the register held before each shift. A bit that enters the data input therefore leaves the data output 8 clock periods later.
- R5: With phase 0, the first output bit (the register MSB) is valid on the data output before the first serial clock edge of the frame.
- R6: When the select rises after a frame of a nonzero whole multiple of 8 clocks, the low 4 bits of the shift register (bit 0 drives switch 0) move to the switch enables one cycle later. The upper 4 bits have no effect on the switch enables.
- R7: When the select rises after a frame whose clock count is not a nonzero multiple of 8, the switch enables keep their previous values.
- R8: The output enable is 0 whenever the synchronized select is high, so the pad is high impedance between frames.
- R9: In a chain of three slaves, a 24-clock frame leaves the first byte sent in the third slave, the second byte in the second slave and the third byte in the first slave. After the select rises, each slave's enables equal the low nibble of its own byte.
- R10: The switch enables never change during a frame or between frames. They change only in the cycle after a valid frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Active-low frame select, shared along the chain |
| ser_in | input | 1 | Serial data in (from the host or the previous slave) |
| ser_out | output | 1 | Serial data out (to the host or the next slave), 0 when not enabled |
| ser_oe | output | 1 | Output enable for the data-out pad buffer |
| sw_en | output | NUM_SW | Switch enable lines, bit 0 drives switch 0 |

## Verification
The bench drives a chain of three slaves in each of the four clock modes. It reads the last slave's output bit by bit and compares it with a queue model of the concatenated registers. An implementation that takes the wrong edge for a mode shows up here as one-bit skew. So does one that misses the first bit in phase 0, or that shifts least significant bit first. The bench toggles the clock and data while the select is high, so a slave that ignores the select would corrupt the next read-back. A 12-clock frame must leave the enables unchanged. A latch on every select rise would overwrite them. Bytes with the upper nibble set catch a design that takes the wrong nibble. A per-cycle comparison of the enables catches any update during a frame.

// File: rtl/spi_sw_pkg.sv
package spi_sw_pkg;

  // Events derived from the synchronized serial pins, one cycle wide each.
  typedef struct packed {
    logic active;       // select is low (synchronized)
    logic lead;         // leading serial clock edge inside a frame
    logic trail;        // trailing serial clock edge inside a frame
    logic frame_start;  // select just fell
    logic frame_end;    // select just rose
  } spi_evt_t;

  function automatic int cnt_width(input int bits);
    return (bits > 1) ? $clog2(bits) : 1;
  endfunction

endpackage

// File: rtl/spi_sw_sync.sv
module spi_sw_sync
  import spi_sw_pkg::*;
#(
  parameter int STAGES = 2,
  parameter bit CPOL   = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ser_clk,
  input  logic     sel_n,
  input  logic     ser_in,
  output spi_evt_t evt,
  output logic     din_s
);

  logic [STAGES-1:0] sk_pipe;
  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] dt_pipe;
  logic              sk_prev;
  logic              cs_prev;
  logic              sk_s;
  logic              cs_s;

  // Same depth on all three paths so data lines up with its clock edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      sk_pipe <= {STAGES{CPOL}};
      cs_pipe <= '1;
      dt_pipe <= '0;
      sk_prev <= CPOL;
      cs_prev <= 1'b1;
    end else begin
      sk_pipe <= {sk_pipe[STAGES-2:0], ser_clk};
      cs_pipe <= {cs_pipe[STAGES-2:0], sel_n};
      dt_pipe <= {dt_pipe[STAGES-2:0], ser_in};
      sk_prev <= sk_pipe[STAGES-1];
      cs_prev <= cs_pipe[STAGES-1];
    end
  end

  assign sk_s  = sk_pipe[STAGES-1];
  assign cs_s  = cs_pipe[STAGES-1];
  assign din_s = dt_pipe[STAGES-1];

  always_comb begin
    evt.active      = ~cs_s;
    evt.lead        = ~cs_s & (sk_prev == CPOL) & (sk_s != CPOL);
    evt.trail       = ~cs_s & (sk_prev != CPOL) & (sk_s == CPOL);
    evt.frame_start = cs_prev & ~cs_s;
    evt.frame_end   = ~cs_prev & cs_s;
  end

endmodule

// File: rtl/spi_sw_shift.sv
module spi_sw_shift
  import spi_sw_pkg::*;
#(
  parameter int BITS = 8,
  parameter bit CPHA = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  spi_evt_t        evt,
  input  logic            din_s,
  output logic [BITS-1:0] sr_q,
  output logic            out_bit,
  output logic            frame_good
);

  localparam int CW = cnt_width(BITS);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          shift_now;
  logic          shift_bit;

  generate
    if (CPHA == 1'b0) begin : g_ph0
      // Sample on leading edge, move into the register on trailing edge.
      logic cap_q;
      always_ff @(posedge clk) begin
        if (rst)           cap_q <= 1'b0;
        else if (evt.lead) cap_q <= din_s;
      end
      assign shift_now = evt.trail;
      assign shift_bit = cap_q;
      assign out_bit   = sr_q[BITS-1];
    end else begin : g_ph1
      // Present the next bit on leading edge, sample on trailing edge.
      logic drv_q;
      always_ff @(posedge clk) begin
        if (rst)                                drv_q <= 1'b0;
        else if (evt.frame_start || evt.lead)   drv_q <= sr_q[BITS-1];
      end
      assign shift_now = evt.trail;
      assign shift_bit = din_s;
      assign out_bit   = drv_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (evt.frame_start) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (shift_now) begin
      sr_q <= {sr_q[BITS-2:0], shift_bit};
      if (cnt_q == CW'(BITS - 1)) begin
        cnt_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign frame_good = evt.frame_end & seen_q & (cnt_q == '0);

endmodule

// File: rtl/spi_sw_outreg.sv
module spi_sw_outreg #(
  parameter int BITS   = 8,
  parameter int NUM_SW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BITS-1:0]   sr,
  output logic [NUM_SW-1:0] sw_q
);

  always_ff @(posedge clk) begin
    if (rst)       sw_q <= '0;
    else if (load) sw_q <= sr[NUM_SW-1:0];
  end

endmodule

// File: rtl/spi_switch_slave.sv
module spi_switch_slave
  import spi_sw_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int NUM_SW      = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit CPOL        = 1'b0,
  parameter bit CPHA        = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              sel_n,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              ser_oe,
  output logic [NUM_SW-1:0] sw_en
);

  spi_evt_t        evt;
  logic            din_s;
  logic [BITS-1:0] sr_q;
  logic            out_bit;
  logic            frame_good;
  logic            oe_q;

  spi_sw_sync #(.STAGES(SYNC_STAGES), .CPOL(CPOL)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .ser_clk (ser_clk),
    .sel_n   (sel_n),
    .ser_in  (ser_in),
    .evt     (evt),
    .din_s   (din_s)
  );

  spi_sw_shift #(.BITS(BITS), .CPHA(CPHA)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .din_s      (din_s),
    .sr_q       (sr_q),
    .out_bit    (out_bit),
    .frame_good (frame_good)
  );

  spi_sw_outreg #(.BITS(BITS), .NUM_SW(NUM_SW)) u_out (
    .clk  (clk),
    .rst  (rst),
    .load (frame_good),
    .sr   (sr_q),
    .sw_q (sw_en)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= evt.active;
  end

  assign ser_oe  = oe_q;
  assign ser_out = out_bit & oe_q;

endmodule

// File: rtl/spi_switch_slave_chk.sv
module spi_switch_slave_chk #(
  parameter int BITS   = 8,
  parameter int NUM_SW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              active,
  input logic              lead,
  input logic              trail,
  input logic              frame_good,
  input logic [BITS-1:0]   sr_q,
  input logic [NUM_SW-1:0] sw_en,
  input logic              ser_oe
);

  p_edge_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead, trail}));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(sr_q));

  p_latch_low_r6: assert property (@(posedge clk) disable iff (rst)
    frame_good |=> (sw_en == $past(sr_q[NUM_SW-1:0])));

  p_sw_steady_r10: assert property (@(posedge clk) disable iff (rst)
    !frame_good |=> $stable(sw_en));

  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    !active |=> !ser_oe);

endmodule

bind spi_switch_slave spi_switch_slave_chk #(.BITS(BITS), .NUM_SW(NUM_SW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .active     (evt.active),
  .lead       (evt.lead),
  .trail      (evt.trail),
  .frame_good (frame_good),
  .sr_q       (sr_q),
  .sw_en      (sw_en),
  .ser_oe     (ser_oe)
);

// File: tb/spi_switch_slave_tb_top.sv
`timescale 1ns/1ps
module spi_switch_slave_tb_top;

  localparam int H = 8;  // system clocks per serial half period

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [3:0] sclk_m;
  logic [3:0] seln_m;
  logic [3:0] mosi_m;
  logic       sdo_w [4][3];
  logic       oe_w  [4][3];
  logic [3:0] sw_w  [4][3];

  int  n_chk = 0;
  int  n_bad = 0;
  bit  chk_en = 1'b0;
  bit  finished = 1'b0;
  logic [3:0]  exp_sw [4][3];
  logic [23:0] chain_st [4];  // [23:16] third slave, [15:8] second, [7:0] first

  for (genvar gm = 0; gm < 4; gm++) begin : g_mode
    for (genvar gk = 0; gk < 3; gk++) begin : g_dev
      logic din;
      if (gk == 0) begin : g_head
        assign din = mosi_m[gm];
      end else begin : g_link
        assign din = sdo_w[gm][gk-1];
      end
      spi_switch_slave #(.CPOL(1'(gm / 2)), .CPHA(1'(gm % 2))) dut_i (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (sclk_m[gm]),
        .sel_n   (seln_m[gm]),
        .ser_in  (din),
        .ser_out (sdo_w[gm][gk]),
        .ser_oe  (oe_w[gm][gk]),
        .sw_en   (sw_w[gm][gk])
      );
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, expv, $time);
    end
  endtask

  // R10: enables compared against the model on every cycle while settled.
  always @(negedge clk) begin
    if (chk_en) begin
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 3; k++)
          if (sw_w[m][k] !== exp_sw[m][k]) chk(1'b0, "R10 per-cycle enables", sw_w[m][k], exp_sw[m][k]);
      n_chk++;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bit-banged host frame on mode m; sends the top n bits of data, MSB first.
  task automatic frame(input int m, input logic [23:0] data, input int n);
    bit q[$];
    logic pol = 1'(m / 2);
    bit   ph1 = (m % 2) == 1;
    q = {};
    for (int i = 23; i >= 0; i--) q.push_back(chain_st[m][i]);
    if (!ph1) mosi_m[m] = data[23];
    seln_m[m] = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic b = data[23-i];
      if (!ph1) begin
        wait_n(H);
        chk(sdo_w[m][2] === q[0], (i == 0) ? "R5 first bit before edge" : "R3 R4 readback", sdo_w[m][2], q[0]);
        sclk_m[m] = ~pol;
        void'(q.pop_front()); q.push_back(b);
        wait_n(H);
        sclk_m[m] = pol;
        if (i + 1 < n) mosi_m[m] = data[22-i];
      end else begin
        wait_n(H);
        sclk_m[m] = ~pol;
        mosi_m[m] = b;
        wait_n(H);
        chk(sdo_w[m][2] === q[0], "R3 R4 readback", sdo_w[m][2], q[0]);
        sclk_m[m] = pol;
        void'(q.pop_front()); q.push_back(b);
      end
    end
    wait_n(H);
    chk_en = 1'b0;
    seln_m[m] = 1'b1;
    for (int i = 0; i < 24; i++) chain_st[m][23-i] = q[i];
    if (n > 0 && (n % 8) == 0) begin
      exp_sw[m][2] = chain_st[m][19:16];
      exp_sw[m][1] = chain_st[m][11:8];
      exp_sw[m][0] = chain_st[m][3:0];
    end
    wait_n(2 * H);
    for (int k = 0; k < 3; k++) begin
      chk(oe_w[m][k] == 1'b0, "R8 output enable off", oe_w[m][k], 0);
      chk(sw_w[m][k] == exp_sw[m][k], (n % 8 == 0) ? "R6 R9 enables after frame" : "R7 partial frame keeps",
          sw_w[m][k], exp_sw[m][k]);
    end
    chk_en = 1'b1;
  endtask

  task automatic idle_noise(input int m);
    for (int i = 0; i < 10; i++) begin
      sclk_m[m] = ~sclk_m[m];
      mosi_m[m] = ~mosi_m[m];
      wait_n(H);
    end
    sclk_m[m] = 1'(m / 2);
    wait_n(H);
    for (int k = 0; k < 3; k++)
      chk(sw_w[m][k] == exp_sw[m][k], "R2 idle toggles ignored", sw_w[m][k], exp_sw[m][k]);
  endtask

  initial begin
    for (int m = 0; m < 4; m++) begin
      sclk_m[m] = 1'(m / 2);
      chain_st[m] = '0;
      for (int k = 0; k < 3; k++) exp_sw[m][k] = '0;
    end
    seln_m = '1;
    mosi_m = '0;
    wait_n(5);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 3; k++) begin
        chk(sw_w[m][k] == 4'h0, "R1 enables in reset", sw_w[m][k], 0);
      end
    rst = 1'b0;
    wait_n(3);
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 3; k++)
        chk(sw_w[m][k] == 4'h0 && oe_w[m][k] == 1'b0, "R1 state after reset", {sw_w[m][k], oe_w[m][k]}, 0);
    chk_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      frame(m, 24'hA5_3C_96, 24);  // R1 readback zeros, R9 per-slave bytes
      idle_noise(m);               // R2
      frame(m, 24'hF1_E2_D4, 24);  // R6 upper nibbles set
      frame(m, 24'h7B_9E_00, 12);  // R7 partial
      frame(m, 24'h5A_C3_00, 16);  // R9 shorter multiple of 8
      frame(m, 24'h0F_80_18, 24);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule